// File: doc/BRIEF.md
# Page-Granular Physical Memory Protection Checker

This block decides, for every memory request of a 64-bit RISC-V hart, whether the request may go out to memory. Machine-mode software programs a small set of protection entries. Each entry has a configuration byte and an address register. Each request presents a physical address, an operation kind (instruction fetch, load or store) and the current privilege. The checker finds the lowest-numbered entry whose region covers the address. It checks the matching permission bit and returns either a grant, or a fault together with the exception cause that the trap logic should raise.

All regions are page-aligned and span whole 4 KB pages. Address bits [11:0] never take part in matching. An entry describes its region in one of two ways. As a power-of-two block, the region is given by that entry's address register alone. As a window, the entry's own address register gives the top and the previous entry's register gives the bottom. A lock bit freezes an entry and also makes its permissions binding on machine mode.

The request path is purely combinational, so the verdict is available in the same cycle as the request. Only the entry registers are clocked. Writes to them take effect at the next rising clock edge.

Top module: `pmp_checker`

## Requirements
- R1: After reset the configuration register and every address register read zero. A user-mode or supervisor-mode request then faults, and a machine-mode request is granted.
- R2: Power-of-two matching. The address register holds physical address bits [55:2]. Register bits [8:0] are treated as ones, so the smallest region is one page. With t trailing ones, the region covers 2^(t+3) bytes at the aligned base. Request address bits [11:0] are ignored, and an address one byte past the region does not match.
- R3: Window matching. An entry matches when prev_page <= page < own_page. Here page is the request address bits [55:12]. own_page is its own register bits [53:10], and prev_page is the same field of the previous entry's register. Entry 0 uses zero as its lower bound. The previous entry's mode does not matter.
- R4: A fetch (op code 0) is checked against the X bit, a load (op code 1) against the R bit, and a store (op code 2 or 3) against the W bit. Within configuration byte i, held at register bits [8i+7:8i], R is bit 0, W is bit 1 and X is bit 2.
- R5: On a fault the cause output is 1 for a fetch, 5 for a load and 7 for a store. On a grant it is 0. Grant and fault are never high together, and both are low while no request is valid.
- R6: When several entries cover an address, the lowest-numbered one decides.
- R7: When no entry covers the address, a machine-mode request (privilege code 3) is granted. Any other privilege code faults.
- R8: A machine-mode request that matches an unlocked entry is granted whatever that entry's permission bits say. A machine-mode request that matches a locked entry is checked like any other.
- R9: When lock bit 7 of a configuration byte is set, writes to that byte and to that entry's address register are ignored until reset. If the entry is also in window mode, writes to the address register of the entry below are ignored as well.
- R10: The mode field is bits [4:3]: 00 off, 01 window, 11 power-of-two. A write of 10 is stored as off. Bits [6:5] always read zero.
- R11: An address register reads back with bits [63:54] zero. Bits [8:0] read as ones in power-of-two mode and as zeros in off or window mode. Bits [53:9] read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Write strobe for the selected register |
| csr_cfg_sel | input | 1 | 1 selects the packed configuration register, 0 selects an address register |
| csr_idx | input | 3 | Address register index when csr_cfg_sel is 0 |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data of the selected register (combinational) |
| req_valid | input | 1 | Request present |
| req_paddr | input | 56 | Physical address of the request |
| req_op | input | 2 | 0 fetch, 1 load, 2 or 3 store |
| req_priv | input | 2 | 0 user, 1 supervisor, 3 machine |
| acc_grant | output | 1 | Request may proceed |
| acc_fault | output | 1 | Request is blocked |
| acc_cause | output | 4 | Exception cause on a fault, 0 otherwise |

## Verification
The bench builds the block with its default of eight entries and a 56-bit physical address. With eight entries it can set up overlapping power-of-two regions to exercise priority, and a window whose lower bound comes from an entry that is switched off. It also has spare entries for the reserved-mode write and for readback of every field. Because the entry count matches the width of the configuration register, every byte of that register is live, and the bench can see lock protection on some bytes while the writes to the others still take effect.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

    localparam int XLEN       = 64;
    localparam int PA_W       = 56;
    localparam int AREG_W     = PA_W - 2;
    localparam int PG_LSB_REG = 10;
    localparam int FORCE_BITS = 9;
    localparam int PAGE_W     = PA_W - 12;

    typedef enum logic [1:0] {
        AM_OFF   = 2'b00,
        AM_TOR   = 2'b01,
        AM_NA4   = 2'b10,
        AM_NAPOT = 2'b11
    } amode_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] rsv;
        amode_e     mode;
        logic       x;
        logic       w;
        logic       r;
    } ecfg_t;

    localparam logic [1:0] OP_FETCH = 2'd0;
    localparam logic [1:0] OP_LOAD  = 2'd1;
    localparam logic [1:0] PRIV_M   = 2'b11;

    localparam logic [3:0] CAUSE_FETCH = 4'd1;
    localparam logic [3:0] CAUSE_LOAD  = 4'd5;
    localparam logic [3:0] CAUSE_STORE = 4'd7;

endpackage

// File: rtl/pmp_csr.sv
module pmp_csr
    import pmp_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic                           cfg_sel,
    input  logic [IDX_W-1:0]               idx,
    input  logic [XLEN-1:0]                wdata,
    output logic [XLEN-1:0]                rdata,
    output ecfg_t [N_ENT-1:0]              cfg_o,
    output logic [N_ENT-1:0][AREG_W-1:0]   addr_o
);

    typedef struct packed {
        ecfg_t [N_ENT-1:0]            cfg;
        logic [N_ENT-1:0][AREG_W-1:0] addr;
    } st_t;

    st_t              st_d, st_q;
    logic [N_ENT-1:0] guard_above;
    logic             idx_ok;

    assign idx_ok = int'(idx) < N_ENT;

    always_comb begin
        guard_above = '0;
        for (int i = 0; i < N_ENT - 1; i++) begin
            guard_above[i] = st_q.cfg[i+1].lock && (st_q.cfg[i+1].mode == AM_TOR);
        end
    end

    always_comb begin
        logic [7:0] nb;
        st_d = st_q;
        nb   = '0;
        if (we && cfg_sel) begin
            for (int i = 0; i < N_ENT; i++) begin
                nb = wdata[8*i +: 8];
                if (!st_q.cfg[i].lock) begin
                    st_d.cfg[i].lock = nb[7];
                    st_d.cfg[i].rsv  = 2'b00;
                    st_d.cfg[i].mode = (nb[4:3] == 2'b10) ? AM_OFF : amode_e'(nb[4:3]);
                    st_d.cfg[i].x    = nb[2];
                    st_d.cfg[i].w    = nb[1];
                    st_d.cfg[i].r    = nb[0];
                end
            end
        end
        if (we && !cfg_sel && idx_ok) begin
            if (!st_q.cfg[idx].lock && !guard_above[idx]) begin
                st_d.addr[idx] = wdata[AREG_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        logic [AREG_W-1:0] view;
        rdata = '0;
        view  = '0;
        if (cfg_sel) begin
            for (int i = 0; i < N_ENT; i++) begin
                rdata[8*i +: 8] = st_q.cfg[i];
            end
        end else if (idx_ok) begin
            view = st_q.addr[idx];
            if (st_q.cfg[idx].mode == AM_NAPOT) view[FORCE_BITS-1:0] = '1;
            else                                view[FORCE_BITS-1:0] = '0;
            rdata[AREG_W-1:0] = view;
        end
    end

    assign cfg_o  = st_q.cfg;
    assign addr_o = st_q.addr;

    for (genvar g = 0; g < N_ENT; g++) begin : g_chk
        p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cfg[g].lock |=> (st_q.cfg[g] == $past(st_q.cfg[g]) &&
                                  st_q.addr[g] == $past(st_q.addr[g])));
        p_no_na4_r10: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cfg[g].mode != AM_NA4 && st_q.cfg[g].rsv == 2'b00);
    end

endmodule

// File: rtl/pmp_region_match.sv
module pmp_region_match
    import pmp_pkg::*;
(
    input  logic [PAGE_W-1:0] page,
    input  amode_e            mode,
    input  logic [AREG_W-1:0] self_reg,
    input  logic [AREG_W-1:0] prev_reg,
    output logic              hit
);

    logic [AREG_W-1:0] napot_reg;
    logic [AREG_W-1:0] napot_mask;
    logic [AREG_W-1:0] req_word;
    logic [PAGE_W-1:0] lo_page, hi_page;

    assign napot_reg  = {self_reg[AREG_W-1:FORCE_BITS], {FORCE_BITS{1'b1}}};
    assign napot_mask = ~(napot_reg ^ (napot_reg + 1'b1));
    assign req_word   = {page, {PG_LSB_REG{1'b0}}};
    assign lo_page    = prev_reg[AREG_W-1:PG_LSB_REG];
    assign hi_page    = self_reg[AREG_W-1:PG_LSB_REG];

    always_comb begin
        unique case (mode)
            AM_TOR:   hit = (page >= lo_page) && (page < hi_page);
            AM_NAPOT: hit = ((req_word ^ napot_reg) & napot_mask) == '0;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
    import pmp_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_we,
    input  logic             csr_cfg_sel,
    input  logic [IDX_W-1:0] csr_idx,
    input  logic [63:0]      csr_wdata,
    output logic [63:0]      csr_rdata,
    input  logic             req_valid,
    input  logic [55:0]      req_paddr,
    input  logic [1:0]       req_op,
    input  logic [1:0]       req_priv,
    output logic             acc_grant,
    output logic             acc_fault,
    output logic [3:0]       acc_cause
);

    ecfg_t [N_ENT-1:0]            cfg_q;
    logic [N_ENT-1:0][AREG_W-1:0] addr_q;
    logic [N_ENT-1:0]             hit_vec;
    logic [PAGE_W-1:0]            page;
    logic                         any_hit;
    ecfg_t                        win_cfg;
    logic                         perm_ok, pass;

    assign page = req_paddr[PA_W-1:12];

    pmp_csr #(.N_ENT(N_ENT)) u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (csr_we),
        .cfg_sel (csr_cfg_sel),
        .idx     (csr_idx),
        .wdata   (csr_wdata),
        .rdata   (csr_rdata),
        .cfg_o   (cfg_q),
        .addr_o  (addr_q)
    );

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic [AREG_W-1:0] prev;
        if (g == 0) begin : g_first
            assign prev = '0;
        end else begin : g_rest
            assign prev = addr_q[g-1];
        end
        pmp_region_match u_match (
            .page     (page),
            .mode     (cfg_q[g].mode),
            .self_reg (addr_q[g]),
            .prev_reg (prev),
            .hit      (hit_vec[g])
        );
    end

    always_comb begin
        any_hit = 1'b0;
        win_cfg = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                win_cfg = cfg_q[i];
            end
        end
    end

    always_comb begin
        if (req_op == OP_FETCH)     perm_ok = win_cfg.x;
        else if (req_op == OP_LOAD) perm_ok = win_cfg.r;
        else                        perm_ok = win_cfg.w;

        if (any_hit) pass = (req_priv == PRIV_M && !win_cfg.lock) ? 1'b1 : perm_ok;
        else         pass = (req_priv == PRIV_M);

        acc_grant = req_valid && pass;
        acc_fault = req_valid && !pass;
        if (!acc_fault)             acc_cause = 4'd0;
        else if (req_op == OP_FETCH) acc_cause = CAUSE_FETCH;
        else if (req_op == OP_LOAD)  acc_cause = CAUSE_LOAD;
        else                         acc_cause = CAUSE_STORE;
    end

    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_grant && acc_fault));
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!acc_grant && !acc_fault && acc_cause == 4'd0));
    p_nomatch_m_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit_vec == '0 && req_priv == PRIV_M) |-> acc_grant);
    p_nomatch_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit_vec == '0 && req_priv != PRIV_M) |-> acc_fault);
    p_first_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit_vec[0] && req_priv != PRIV_M && req_op == OP_LOAD)
            |-> (acc_grant == cfg_q[0].r));

endmodule

// File: tb/pmp_checker_test.sv
module pmp_checker_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic        csr_cfg_sel = 1'b0;
    logic [2:0]  csr_idx = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        req_valid = 1'b0;
    logic [55:0] req_paddr = '0;
    logic [1:0]  req_op = '0;
    logic [1:0]  req_priv = '0;
    logic        acc_grant, acc_fault;
    logic [3:0]  acc_cause;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmp_checker uut (
        .clk(clk), .rst_n(rst_n),
        .csr_we(csr_we), .csr_cfg_sel(csr_cfg_sel), .csr_idx(csr_idx),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .req_valid(req_valid), .req_paddr(req_paddr), .req_op(req_op),
        .req_priv(req_priv),
        .acc_grant(acc_grant), .acc_fault(acc_fault), .acc_cause(acc_cause)
    );

    typedef struct packed {
        logic [55:0] a;
        logic [1:0]  op;
        logic [1:0]  pv;
        logic        g;
        logic [3:0]  c;
        logic [3:0]  rq;
    } vec_t;

    // Entries: 0 window [0,0x1000_0000) RX; 1 block 64KB @0x8000_0000 R;
    // 2 block 1MB @0x8000_0000 RW; 3 off (bound 0x2000_0000);
    // 4 window [0x2000_0000,0x3000_0000) X; 5 block 4KB @0x4000_0000 W.
    localparam vec_t VEC [17] = '{
        '{56'h0000_0000, 2'd0, 2'd0, 1'b1, 4'd0, 4'd4},  // R4 fetch uses X
        '{56'h0FFF_FFFF, 2'd2, 2'd1, 1'b0, 4'd7, 4'd3},  // R3 top page inside
        '{56'h1000_0000, 2'd1, 2'd0, 1'b0, 4'd5, 4'd3},  // R3 exclusive top
        '{56'h1000_0000, 2'd1, 2'd3, 1'b1, 4'd0, 4'd7},  // R7 machine no match
        '{56'h8000_0FFF, 2'd2, 2'd0, 1'b0, 4'd7, 4'd6},  // R6 entry1 wins
        '{56'h8000_FFFF, 2'd1, 2'd0, 1'b1, 4'd0, 4'd2},  // R2 last byte
        '{56'h8001_0000, 2'd2, 2'd0, 1'b1, 4'd0, 4'd6},  // R6 only entry2
        '{56'h800F_FFFF, 2'd0, 2'd1, 1'b0, 4'd1, 4'd5},  // R5 fetch cause
        '{56'h8010_0000, 2'd1, 2'd1, 1'b0, 4'd5, 4'd2},  // R2 one past block
        '{56'h2000_0000, 2'd0, 2'd0, 1'b1, 4'd0, 4'd3},  // R3 bound from off entry
        '{56'h1FFF_FFFF, 2'd0, 2'd0, 1'b0, 4'd1, 4'd7},  // R7 user no match
        '{56'h2FFF_FFFF, 2'd1, 2'd0, 1'b0, 4'd5, 4'd4},  // R4 load uses R
        '{56'h4000_0ABC, 2'd2, 2'd0, 1'b1, 4'd0, 4'd2},  // R2 low bits ignored
        '{56'h4000_1000, 2'd3, 2'd0, 1'b0, 4'd7, 4'd2},  // R2 page past, op3 store
        '{56'h8000_0000, 2'd2, 2'd3, 1'b1, 4'd0, 4'd8},  // R8 unlocked machine
        '{56'h2000_0000, 2'd1, 2'd3, 1'b1, 4'd0, 4'd8},  // R8 unlocked machine
        '{56'h0000_1234, 2'd1, 2'd0, 1'b1, 4'd0, 4'd4}   // R4 load granted
    };

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic csr_write(input logic sel, input logic [2:0] idx, input logic [63:0] d);
        @(negedge clk);
        csr_cfg_sel = sel; csr_idx = idx; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_read(input string tag, input logic sel, input logic [2:0] idx,
                            input logic [63:0] exp);
        @(negedge clk);
        csr_cfg_sel = sel; csr_idx = idx;
        #1;
        chk(tag, csr_rdata, exp);
    endtask

    task automatic request(input string tag, input logic [55:0] a, input logic [1:0] op,
                           input logic [1:0] pv, input logic g, input logic [3:0] c);
        @(negedge clk);
        req_valid = 1'b1; req_paddr = a; req_op = op; req_priv = pv;
        #1;
        chk(tag, {58'd0, acc_grant, acc_fault, acc_cause}, {58'd0, g, !g, c});
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog got=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        csr_read("R1 cfg after reset", 1'b1, 3'd0, 64'h0);
        csr_read("R1 addr0 after reset", 1'b0, 3'd0, 64'h0);
        request("R1 user load after reset", 56'h0, 2'd1, 2'd0, 1'b0, 4'd5);
        request("R1 machine store after reset", 56'h0, 2'd2, 2'd3, 1'b1, 4'd0);
        // R5 idle request
        @(negedge clk);
        req_valid = 1'b0; req_paddr = 56'h0; req_priv = 2'd0;
        #1;
        chk("R5 idle outputs", {58'd0, acc_grant, acc_fault, acc_cause}, 64'h0);

        // program entries
        csr_write(1'b0, 3'd0, 64'h0000_0000_0400_01FF);
        csr_write(1'b0, 3'd1, 64'h0000_0000_2000_1FFF);
        csr_write(1'b0, 3'd2, 64'h0000_0000_2001_FFFF);
        csr_write(1'b0, 3'd3, 64'h0000_0000_0800_0000);
        csr_write(1'b0, 3'd4, 64'h0000_0000_0C00_0000);
        csr_write(1'b0, 3'd5, 64'h0000_0000_1000_0000);
        csr_write(1'b0, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
        csr_write(1'b1, 3'd0, 64'h0071_1A0C_001B_190D);

        // R10 reserved mode stored as off, bits 6:5 cleared
        csr_read("R10 cfg readback", 1'b1, 3'd0, 64'h0001_1A0C_001B_190D);
        // R11 address readback
        csr_read("R11 window low bits zero", 1'b0, 3'd0, 64'h0000_0000_0400_0000);
        csr_read("R11 block low bits one", 1'b0, 3'd5, 64'h0000_0000_1000_01FF);
        csr_read("R11 block readback", 1'b0, 3'd1, 64'h0000_0000_2000_1FFF);
        csr_read("R11 upper bits zero", 1'b0, 3'd7, 64'h003F_FFFF_FFFF_FE00);

        for (int k = 0; k < 17; k++) begin
            request($sformatf("R%0d vector %0d", VEC[k].rq, k), VEC[k].a, VEC[k].op,
                    VEC[k].pv, VEC[k].g, VEC[k].c);
        end

        // R8 / R9 lock entries 1 and 4
        csr_write(1'b1, 3'd0, 64'h0001_1A8C_001B_990D);
        request("R8 locked entry binds machine store", 56'h8000_0000, 2'd2, 2'd3, 1'b0, 4'd7);
        request("R8 locked entry machine fetch", 56'h2000_0000, 2'd0, 2'd3, 1'b1, 4'd0);
        request("R8 locked entry machine load", 56'h2000_0000, 2'd1, 2'd3, 1'b0, 4'd5);
        csr_write(1'b1, 3'd0, 64'h0);
        csr_read("R9 locked bytes kept", 1'b1, 3'd0, 64'h0000_008C_0000_9900);
        csr_write(1'b0, 3'd1, 64'h0);
        csr_read("R9 locked address kept", 1'b0, 3'd1, 64'h0000_0000_2000_1FFF);
        csr_write(1'b0, 3'd3, 64'h0);
        csr_read("R9 address below locked window kept", 1'b0, 3'd3, 64'h0000_0000_0800_0000);
        csr_write(1'b0, 3'd4, 64'h0);
        csr_read("R9 locked window address kept", 1'b0, 3'd4, 64'h0000_0000_0C00_0000);
        csr_write(1'b0, 3'd2, 64'h0000_0000_0000_1600);
        csr_read("R9 unlocked address writable", 1'b0, 3'd2, 64'h0000_0000_0000_1600);

        // R1 reset clears locks
        do_reset();
        csr_read("R1 cfg after second reset", 1'b1, 3'd0, 64'h0);
        csr_read("R1 addr1 after second reset", 1'b0, 3'd1, 64'h0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule